// File: doc/BRIEF.md
# Parallel NOR Flash Command Sequencer

This block is a synthesizable behavioural model of the command front end of a byte-wide parallel NOR flash. It watches a bus with an 18-bit address, an 8-bit data path and active-low chip enable, output enable and write enable. The bus strobes are sampled on a system clock. Keyed multi-cycle write sequences are decoded into byte program, whole-array erase, a one-time lock of the low 8K boot region, and entry to and exit from an identification read mode.

Program and erase run for a fixed number of clock cycles set by parameters. While one is running, reads return a polling status byte and not array contents. A small on-chip store stands in for the array. It has two banks of 2^BANK_AW bytes: one bank for the boot region and one for the rest of the address space. Within its region, each bank aliases on the low BANK_AW address bits. Erase sweeps one location per cycle and therefore needs ERASE_CYC >= 2^BANK_AW.

Top module: `nor_cmd_fsm`

## Requirements
- R1: An active-low reset returns the decoder to idle, leaves the block not busy, leaves identification mode, and clears the boot lock. While no read is in progress, data_oe_o is 0 and data_o is 0x00.
- R2: A read is in progress while ce_ni=0, oe_ni=0 and we_ni=1. During a read, data_oe_o=1, and when the block is idle and not in identification mode, data_o shows the stored byte at addr_i.
- R3: Byte program is four writes: 0xAA to 0x5555, 0x55 to 0x2AAA, 0xA0 to 0x5555, then the data byte to the target address. The stored byte becomes old AND new. Only addr bits [14:0] are compared in the key writes.
- R4: Whole-array erase is six writes: 0xAA/0x5555, 0x55/0x2AAA, 0x80/0x5555, 0xAA/0x5555, 0x55/0x2AAA, 0x10/0x5555. Every unprotected byte then reads 0xFF.
- R5: The same six writes ending in 0x40 set the boot lock. From then on, addresses 0x00000 to 0x01FFF (addr[17:13]=0) are never programmed or erased, while address 0x02000 and above still are.
- R6: Writing 0xAA/0x5555, 0x55/0x2AAA, 0x90/0x5555 enters identification mode. In this mode, address 0 reads 0x1F, address 1 reads 0x0B, and address 2 reads the lock state in bit 0 (1 = locked). Every other address reads 0x00. A write of 0xF0 to any address exits the mode, and so does 0xAA/0x5555, 0x55/0x2AAA, 0xF0/0x5555.
- R7: A program is busy for PROG_CYC cycles and an erase for ERASE_CYC cycles. While busy, a read returns a status byte with bits [5:0]=0. Bit 6 inverts on each successive read. Bit 7 is the complement of bit 7 of the loaded data when addr_i equals the address being programmed, and 0 otherwise, including during erase.
- R8: A write cycle begins when ce_ni and we_ni are both low, and the address is captured at that point. It ends when either strobe rises, and the data is captured at that point. A write that ends while oe_ni is low is discarded.
- R9: A write that does not match the expected next step returns the decoder to idle. Any write of 0xF0 forces idle and normal reads, even in place of the program data byte.
- R10: Writes that end while the block is busy are ignored and do not change the decoder, the identification mode or the lock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Sampling clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 18 | Byte address |
| data_i | input | 8 | Write data |
| ce_ni | input | 1 | Chip enable, active low |
| oe_ni | input | 1 | Output enable, active low |
| we_ni | input | 1 | Write enable, active low |
| data_o | output | 8 | Read data or status |
| data_oe_o | output | 1 | High while the block drives read data |

## Verification
The bench targets the following corner cases, each paired with the failure it exposes:
- Key writes at aliased high addresses: a decoder that compared the full address would lose these.
- A broken unlock step, and 0xF0 sent in place of the program data byte: a sticky decoder would program a byte.
- Writes at 0x01FFF and 0x02000 after the lock: an off-by-one boot boundary would show up here.
- A second erase after the lock: an erase that ignored the lock would wipe the boot bytes.
- Status polling: the bench compares bit 7 at the loaded address against another address, and compares bit 6 across back-to-back reads. This catches a swapped or frozen status bit.
- A write whose address moves after the strobes fall: a late address latch would be caught.
- A write made with output enable low: a design that did not discard it would be caught.
- An identification-entry sequence issued while busy: a design that did not ignore it would then return 0x00 in place of array data.

// File: rtl/nor_cmd_pkg.sv
package nor_cmd_pkg;
  localparam int DW     = 8;
  localparam int KEY_AW = 15;

  localparam logic [KEY_AW-1:0] KEY_A1 = 15'h5555;
  localparam logic [KEY_AW-1:0] KEY_A2 = 15'h2AAA;

  localparam logic [DW-1:0] C_UNLK1 = 8'hAA;
  localparam logic [DW-1:0] C_UNLK2 = 8'h55;
  localparam logic [DW-1:0] C_PGM   = 8'hA0;
  localparam logic [DW-1:0] C_XPRE  = 8'h80;
  localparam logic [DW-1:0] C_ERS   = 8'h10;
  localparam logic [DW-1:0] C_LOCK  = 8'h40;
  localparam logic [DW-1:0] C_IDENT = 8'h90;
  localparam logic [DW-1:0] C_RESET = 8'hF0;

  localparam logic [DW-1:0] ID_MFR = 8'h1F;
  localparam logic [DW-1:0] ID_DEV = 8'h0B;
  localparam logic [DW-1:0] ERASED = 8'hFF;

  typedef enum logic [2:0] {
    S_IDLE,
    S_K1,
    S_K2,
    S_PGM,
    S_XPRE,
    S_XK1,
    S_XK2
  } seq_e;
endpackage

// File: rtl/nor_bus_sample.sv
module nor_bus_sample #(
  parameter int ADDR_W = 18
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              ce_ni,
  input  logic              oe_ni,
  input  logic              we_ni,
  output logic              wr_end_o,
  output logic [ADDR_W-1:0] wr_addr_o,
  output logic              rd_act_o,
  output logic              rd_start_o
);
  logic wr_act, wr_q, rd_q;
  logic [ADDR_W-1:0] addr_q;

  assign wr_act   = ~ce_ni & ~we_ni;
  assign rd_act_o = ~ce_ni & ~oe_ni & we_ni;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_q   <= 1'b0;
      rd_q   <= 1'b0;
      addr_q <= '0;
    end else begin
      wr_q <= wr_act;
      rd_q <= rd_act_o;
      // later falling strobe opens the cycle: capture address
      if (wr_act && !wr_q) addr_q <= addr_i;
    end
  end

  // earlier rising strobe closes the cycle; data is taken from the bus now
  assign wr_end_o   = wr_q & ~wr_act & oe_ni;
  assign wr_addr_o  = addr_q;
  assign rd_start_o = rd_act_o & ~rd_q;
endmodule

// File: rtl/nor_seq_dec.sv
module nor_seq_dec
  import nor_cmd_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cmd_vld_i,
  input  logic [KEY_AW-1:0] cmd_addr_i,
  input  logic [DW-1:0]     cmd_data_i,
  output logic              pgm_go_o,
  output logic              ers_go_o,
  output logic              lock_go_o,
  output logic              id_mode_o
);
  seq_e st_q, st_d;
  logic id_q, id_d;
  logic at_a1, at_a2, is_reset;

  assign at_a1    = (cmd_addr_i == KEY_A1);
  assign at_a2    = (cmd_addr_i == KEY_A2);
  assign is_reset = (cmd_data_i == C_RESET);

  always_comb begin
    st_d = S_IDLE;
    id_d = id_q;
    if (is_reset) begin
      id_d = 1'b0;
    end else begin
      unique case (st_q)
        S_IDLE: if (at_a1 && cmd_data_i == C_UNLK1) st_d = S_K1;
        S_K1:   if (at_a2 && cmd_data_i == C_UNLK2) st_d = S_K2;
        S_K2: begin
          if (at_a1 && cmd_data_i == C_PGM)   st_d = S_PGM;
          if (at_a1 && cmd_data_i == C_XPRE)  st_d = S_XPRE;
          if (at_a1 && cmd_data_i == C_IDENT) id_d = 1'b1;
        end
        S_PGM:  st_d = S_IDLE;
        S_XPRE: if (at_a1 && cmd_data_i == C_UNLK1) st_d = S_XK1;
        S_XK1:  if (at_a2 && cmd_data_i == C_UNLK2) st_d = S_XK2;
        S_XK2:  st_d = S_IDLE;
        default: st_d = S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q <= S_IDLE;
      id_q <= 1'b0;
    end else if (cmd_vld_i) begin
      st_q <= st_d;
      id_q <= id_d;
    end
  end

  assign pgm_go_o  = cmd_vld_i && !is_reset && st_q == S_PGM;
  assign ers_go_o  = cmd_vld_i && st_q == S_XK2 && at_a1 && cmd_data_i == C_ERS;
  assign lock_go_o = cmd_vld_i && st_q == S_XK2 && at_a1 && cmd_data_i == C_LOCK;
  assign id_mode_o = id_q;
endmodule

// File: rtl/nor_op_timer.sv
module nor_op_timer #(
  parameter int PROG_CYC  = 16,
  parameter int ERASE_CYC = 1100,
  parameter int CNT_W     = 11
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             pgm_go_i,
  input  logic             ers_go_i,
  input  logic             rd_start_i,
  output logic             busy_o,
  output logic             ers_o,
  output logic [CNT_W-1:0] cnt_o,
  output logic             tog_o
);
  localparam logic [CNT_W-1:0] PGM_LIM = CNT_W'(PROG_CYC - 1);
  localparam logic [CNT_W-1:0] ERS_LIM = CNT_W'(ERASE_CYC - 1);

  logic busy_q, ers_q, tog_q;
  logic [CNT_W-1:0] cnt_q, lim;

  assign lim = ers_q ? ERS_LIM : PGM_LIM;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      ers_q  <= 1'b0;
      cnt_q  <= '0;
      tog_q  <= 1'b0;
    end else begin
      if (rd_start_i && busy_q) tog_q <= ~tog_q;
      if (!busy_q) begin
        if (pgm_go_i || ers_go_i) begin
          busy_q <= 1'b1;
          ers_q  <= ers_go_i;
          cnt_q  <= '0;
        end
      end else if (cnt_q == lim) begin
        busy_q <= 1'b0;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign busy_o = busy_q;
  assign ers_o  = ers_q;
  assign cnt_o  = cnt_q;
  assign tog_o  = tog_q;
endmodule

// File: rtl/nor_array.sv
module nor_array
  import nor_cmd_pkg::*;
#(
  parameter int BANK_AW = 10
) (
  input  logic                  clk_i,
  input  logic                  pgm_en_i,
  input  logic                  pgm_boot_i,
  input  logic [BANK_AW-1:0]    pgm_idx_i,
  input  logic [DW-1:0]         pgm_data_i,
  input  logic                  swp_en_i,
  input  logic                  swp_keep_boot_i,
  input  logic [BANK_AW-1:0]    swp_idx_i,
  input  logic [BANK_AW-1:0]    rd_idx_i,
  output logic [1:0][DW-1:0]    rd_data_o,
  output logic                  boot_we_o
);
  localparam int DEPTH = 1 << BANK_AW;

  logic [1:0] pg, sw;

  // bank 0 holds the boot region, bank 1 the rest
  for (genvar b = 0; b < 2; b++) begin : g_bank
    logic [DW-1:0] mem [DEPTH];

    assign pg[b] = pgm_en_i & ((b == 0) ? pgm_boot_i : ~pgm_boot_i);
    assign sw[b] = swp_en_i & ((b == 0) ? ~swp_keep_boot_i : 1'b1);

    always_ff @(posedge clk_i) begin
      if (pg[b])      mem[pgm_idx_i] <= mem[pgm_idx_i] & pgm_data_i;
      else if (sw[b]) mem[swp_idx_i] <= ERASED;
    end

    assign rd_data_o[b] = mem[rd_idx_i];
  end

  assign boot_we_o = pg[0] | sw[0];
endmodule

// File: rtl/nor_cmd_fsm.sv
module nor_cmd_fsm
  import nor_cmd_pkg::*;
#(
  parameter int ADDR_W    = 18,
  parameter int BOOT_AW   = 13,
  parameter int BANK_AW   = 10,
  parameter int PROG_CYC  = 16,
  parameter int ERASE_CYC = 1100
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DW-1:0]     data_i,
  input  logic              ce_ni,
  input  logic              oe_ni,
  input  logic              we_ni,
  output logic [DW-1:0]     data_o,
  output logic              data_oe_o
);
  localparam int DEPTH   = 1 << BANK_AW;
  localparam int MAX_CYC = (PROG_CYC > ERASE_CYC) ? PROG_CYC : ERASE_CYC;
  localparam int CNT_W   = $clog2(MAX_CYC + 1);

  if (ERASE_CYC < DEPTH) begin : g_bad_cfg
    $error("ERASE_CYC must cover one sweep of a bank");
  end

  logic              wr_end, rd_act, rd_start;
  logic [ADDR_W-1:0] wr_addr;
  logic              cmd_vld;
  logic              pgm_go, ers_go, lock_go, id_mode;
  logic              pgm_ok, wr_boot, rd_boot;
  logic              busy_q, ers_q, tog_q, lock_q;
  logic [CNT_W-1:0]  cnt_q;
  logic              swp_en, boot_we;
  logic [ADDR_W-1:0] pa_q;
  logic              pd7_q;
  logic [1:0][DW-1:0] bank_rd;
  logic [DW-1:0]     arr_byte, id_byte, stat_byte, rd_mux;
  logic              poll7;

  nor_bus_sample #(.ADDR_W(ADDR_W)) u_bus (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .addr_i     (addr_i),
    .ce_ni      (ce_ni),
    .oe_ni      (oe_ni),
    .we_ni      (we_ni),
    .wr_end_o   (wr_end),
    .wr_addr_o  (wr_addr),
    .rd_act_o   (rd_act),
    .rd_start_o (rd_start)
  );

  assign cmd_vld = wr_end & ~busy_q;

  nor_seq_dec u_dec (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .cmd_vld_i  (cmd_vld),
    .cmd_addr_i (wr_addr[KEY_AW-1:0]),
    .cmd_data_i (data_i),
    .pgm_go_o   (pgm_go),
    .ers_go_o   (ers_go),
    .lock_go_o  (lock_go),
    .id_mode_o  (id_mode)
  );

  assign wr_boot = ~|wr_addr[ADDR_W-1:BOOT_AW];
  assign rd_boot = ~|addr_i[ADDR_W-1:BOOT_AW];
  assign pgm_ok  = pgm_go & ~(lock_q & wr_boot);

  nor_op_timer #(
    .PROG_CYC  (PROG_CYC),
    .ERASE_CYC (ERASE_CYC),
    .CNT_W     (CNT_W)
  ) u_tmr (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .pgm_go_i   (pgm_ok),
    .ers_go_i   (ers_go),
    .rd_start_i (rd_start),
    .busy_o     (busy_q),
    .ers_o      (ers_q),
    .cnt_o      (cnt_q),
    .tog_o      (tog_q)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lock_q <= 1'b0;
      pa_q   <= '0;
      pd7_q  <= 1'b0;
    end else begin
      if (lock_go) lock_q <= 1'b1;
      if (pgm_ok) begin
        pa_q  <= wr_addr;
        pd7_q <= data_i[DW-1];
      end
    end
  end

  assign swp_en = busy_q & ers_q & (32'(cnt_q) < 32'(DEPTH));

  nor_array #(.BANK_AW(BANK_AW)) u_arr (
    .clk_i           (clk_i),
    .pgm_en_i        (pgm_ok),
    .pgm_boot_i      (wr_boot),
    .pgm_idx_i       (wr_addr[BANK_AW-1:0]),
    .pgm_data_i      (data_i),
    .swp_en_i        (swp_en),
    .swp_keep_boot_i (lock_q),
    .swp_idx_i       (cnt_q[BANK_AW-1:0]),
    .rd_idx_i        (addr_i[BANK_AW-1:0]),
    .rd_data_o       (bank_rd),
    .boot_we_o       (boot_we)
  );

  assign arr_byte = rd_boot ? bank_rd[0] : bank_rd[1];

  always_comb begin
    id_byte = '0;
    if (~|addr_i[ADDR_W-1:2]) begin
      unique case (addr_i[1:0])
        2'd0:    id_byte = ID_MFR;
        2'd1:    id_byte = ID_DEV;
        2'd2:    id_byte = {{(DW-1){1'b0}}, lock_q};
        default: id_byte = '0;
      endcase
    end
  end

  assign poll7     = ~ers_q & (addr_i == pa_q) & ~pd7_q;
  assign stat_byte = {poll7, tog_q, {(DW-2){1'b0}}};

  always_comb begin
    if (busy_q)       rd_mux = stat_byte;
    else if (id_mode) rd_mux = id_byte;
    else              rd_mux = arr_byte;
  end

  assign data_o    = rd_act ? rd_mux : '0;
  assign data_oe_o = rd_act;
endmodule

// File: rtl/nor_cmd_fsm_chk.sv
module nor_cmd_fsm_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       busy_i,
  input logic       wr_end_i,
  input logic       id_mode_i,
  input logic       lock_i,
  input logic       boot_we_i,
  input logic       rd_start_i,
  input logic       tog_i,
  input logic       data_oe_i,
  input logic [7:0] data_i
);
  p_lock_sticky_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lock_i |=> lock_i);

  p_boot_guard_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lock_i |-> !boot_we_i);

  p_busy_freeze_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_i |=> ($stable(id_mode_i) && $stable(lock_i)));

  p_start_from_cmd_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_i) |-> $past(wr_end_i));

  p_toggle_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_i && rd_start_i) |=> (tog_i != $past(tog_i)));

  p_status_low_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_i && data_oe_i) |-> (data_i[5:0] == 6'd0));
endmodule

bind nor_cmd_fsm nor_cmd_fsm_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .busy_i     (busy_q),
  .wr_end_i   (wr_end),
  .id_mode_i  (id_mode),
  .lock_i     (lock_q),
  .boot_we_i  (boot_we),
  .rd_start_i (rd_start),
  .tog_i      (tog_q),
  .data_oe_i  (data_oe_o),
  .data_i     (data_o)
);

// File: tb/nor_cmd_fsm_tb_top.sv
module nor_cmd_fsm_tb_top;
  localparam int PROG_CYC  = 16;
  localparam int ERASE_CYC = 1100;
  localparam int NV        = 54;

  // {op[1:0], addr[17:0], data/expect[7:0], req[3:0]}; op 0 write, 1 read, 2 wait addr cycles
  localparam logic [31:0] VEC [NV] = '{
    {2'd0, 18'h05555, 8'hAA, 4'd4},  // R4 erase
    {2'd0, 18'h02AAA, 8'h55, 4'd4},
    {2'd0, 18'h05555, 8'h80, 4'd4},
    {2'd0, 18'h05555, 8'hAA, 4'd4},
    {2'd0, 18'h02AAA, 8'h55, 4'd4},
    {2'd0, 18'h05555, 8'h10, 4'd4},
    {2'd2, 18'd1105,  8'h00, 4'd4},
    {2'd1, 18'h00100, 8'hFF, 4'd4},
    {2'd1, 18'h3FFFF, 8'hFF, 4'd4},
    {2'd0, 18'h05555, 8'hAA, 4'd3},  // R3 program
    {2'd0, 18'h02AAA, 8'h55, 4'd3},
    {2'd0, 18'h05555, 8'hA0, 4'd3},
    {2'd0, 18'h00100, 8'h3A, 4'd3},
    {2'd2, 18'd20,    8'h00, 4'd3},
    {2'd1, 18'h00100, 8'h3A, 4'd2},  // R2 plain read
    {2'd0, 18'h05555, 8'hAA, 4'd3},
    {2'd0, 18'h02AAA, 8'h55, 4'd3},
    {2'd0, 18'h05555, 8'hA0, 4'd3},
    {2'd0, 18'h00100, 8'hF5, 4'd3},
    {2'd2, 18'd20,    8'h00, 4'd3},
    {2'd1, 18'h00100, 8'h30, 4'd3},  // R3 AND
    {2'd0, 18'h1D555, 8'hAA, 4'd3},  // R3 high bits ignored
    {2'd0, 18'h3AAAA, 8'h55, 4'd3},
    {2'd0, 18'h0D555, 8'hA0, 4'd3},
    {2'd0, 18'h20010, 8'h81, 4'd3},
    {2'd2, 18'd20,    8'h00, 4'd3},
    {2'd1, 18'h20010, 8'h81, 4'd3},
    {2'd0, 18'h05555, 8'hAA, 4'd9},  // R9 broken key
    {2'd0, 18'h02AAB, 8'h55, 4'd9},
    {2'd0, 18'h05555, 8'hA0, 4'd9},
    {2'd0, 18'h00100, 8'h00, 4'd9},
    {2'd1, 18'h00100, 8'h30, 4'd9},
    {2'd0, 18'h05555, 8'hAA, 4'd9},  // R9 F0 as data byte
    {2'd0, 18'h02AAA, 8'h55, 4'd9},
    {2'd0, 18'h05555, 8'hA0, 4'd9},
    {2'd0, 18'h00100, 8'hF0, 4'd9},
    {2'd1, 18'h00100, 8'h30, 4'd9},
    {2'd0, 18'h05555, 8'hAA, 4'd6},  // R6 ident entry
    {2'd0, 18'h02AAA, 8'h55, 4'd6},
    {2'd0, 18'h05555, 8'h90, 4'd6},
    {2'd1, 18'h00000, 8'h1F, 4'd6},
    {2'd1, 18'h00001, 8'h0B, 4'd6},
    {2'd1, 18'h00002, 8'h00, 4'd6},
    {2'd1, 18'h00005, 8'h00, 4'd6},
    {2'd0, 18'h12345, 8'hF0, 4'd6},
    {2'd1, 18'h00000, 8'hFF, 4'd6},
    {2'd0, 18'h05555, 8'hAA, 4'd6},
    {2'd0, 18'h02AAA, 8'h55, 4'd6},
    {2'd0, 18'h05555, 8'h90, 4'd6},
    {2'd1, 18'h00001, 8'h0B, 4'd6},
    {2'd0, 18'h05555, 8'hAA, 4'd6},  // R6 keyed exit
    {2'd0, 18'h02AAA, 8'h55, 4'd6},
    {2'd0, 18'h05555, 8'hF0, 4'd6},
    {2'd1, 18'h00001, 8'hFF, 4'd6}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [17:0] addr = '0;
  logic [7:0]  din = '0;
  logic        ce_n = 1'b1, oe_n = 1'b1, we_n = 1'b1;
  logic [7:0]  dq;
  logic        dq_oe;
  int          n_vec = 0, n_bad = 0;

  always #5 clk = ~clk;

  nor_cmd_fsm #(.PROG_CYC(PROG_CYC), .ERASE_CYC(ERASE_CYC)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .data_i(din),
    .ce_ni(ce_n), .oe_ni(oe_n), .we_ni(we_n),
    .data_o(dq), .data_oe_o(dq_oe)
  );

  task automatic chk(input logic [7:0] act, input logic [7:0] exp, input string req);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_wr(input logic [17:0] a, input logic [7:0] d, input bit oe_lo = 1'b0);
    @(negedge clk);
    addr = a; din = d; oe_n = ~oe_lo; ce_n = 1'b0; we_n = 1'b0;
    @(negedge clk);
    we_n = 1'b1;
    @(negedge clk);
    ce_n = 1'b1; oe_n = 1'b1;
  endtask

  task automatic bus_rd(input logic [17:0] a, output logic [7:0] v, output logic oe);
    @(negedge clk);
    addr = a; ce_n = 1'b0; oe_n = 1'b0; we_n = 1'b1;
    @(negedge clk);
    v = dq; oe = dq_oe;
    ce_n = 1'b1; oe_n = 1'b1;
  endtask

  task automatic rd_chk(input logic [17:0] a, input logic [7:0] exp, input string req);
    logic [7:0] v;
    logic       oe;
    bus_rd(a, v, oe);
    chk(v, exp, req);
  endtask

  task automatic unlock();
    bus_wr(18'h05555, 8'hAA);
    bus_wr(18'h02AAA, 8'h55);
  endtask

  task automatic prog(input logic [17:0] a, input logic [7:0] d);
    unlock();
    bus_wr(18'h05555, 8'hA0);
    bus_wr(a, d);
  endtask

  task automatic six(input logic [7:0] last);
    unlock();
    bus_wr(18'h05555, 8'h80);
    unlock();
    bus_wr(18'h05555, last);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    logic [7:0] v1, v2, v3;
    logic       o1;
    idle(3);
    chk({7'd0, dq_oe}, 8'h00, "R1 oe in reset");
    chk(dq, 8'h00, "R1 data in reset");
    rst_n = 1'b1;
    idle(2);
    chk({7'd0, dq_oe}, 8'h00, "R1 oe idle");

    for (int i = 0; i < NV; i++) begin
      logic [31:0] v;
      v = VEC[i];
      unique case (v[31:30])
        2'd0: bus_wr(v[29:12], v[11:4]);
        2'd1: rd_chk(v[29:12], v[11:4], $sformatf("R%0d vec %0d", v[3:0], i));
        default: idle(int'(v[29:12]));
      endcase
    end

    // R2: output enable asserted during a read
    bus_rd(18'h00100, v1, o1);
    chk({7'd0, o1}, 8'h01, "R2 oe during read");

    // R5: boot programmable before lock, then lock
    prog(18'h00200, 8'h55); idle(PROG_CYC + 4);
    rd_chk(18'h00200, 8'h55, "R5 boot before lock");
    six(8'h40);
    unlock(); bus_wr(18'h05555, 8'h90);
    rd_chk(18'h00002, 8'h01, "R6 lock bit");
    bus_wr(18'h00000, 8'hF0);
    prog(18'h00300, 8'h00); idle(PROG_CYC + 4);
    rd_chk(18'h00300, 8'hFF, "R5 boot locked");
    prog(18'h01FFF, 8'h00); idle(PROG_CYC + 4);
    rd_chk(18'h01FFF, 8'hFF, "R5 boot top locked");
    prog(18'h02000, 8'h12); idle(PROG_CYC + 4);
    rd_chk(18'h02000, 8'h12, "R5 main lowest");

    // R7: polling while programming
    prog(18'h04040, 8'h5A);
    bus_rd(18'h04040, v1, o1);
    bus_rd(18'h04040, v2, o1);
    bus_rd(18'h04041, v3, o1);
    chk(v1 & 8'hBF, 8'h80, "R7 poll bit7 at target");
    chk({7'd0, v2[6]}, {7'd0, ~v1[6]}, "R7 toggle");
    chk(v3 & 8'hBF, 8'h00, "R7 poll other addr");
    idle(PROG_CYC + 4);
    rd_chk(18'h04040, 8'h5A, "R7 data after busy");

    // R10: ident entry while busy is dropped
    prog(18'h04080, 8'h0F);
    unlock(); bus_wr(18'h05555, 8'h90);
    idle(PROG_CYC + 4);
    rd_chk(18'h04080, 8'h0F, "R10 busy ignores cmds");

    // R8: write with output enable low is discarded
    unlock(); bus_wr(18'h05555, 8'hA0);
    bus_wr(18'h040C0, 8'h00, 1'b1);
    bus_wr(18'h00000, 8'hF0);
    idle(PROG_CYC + 4);
    rd_chk(18'h040C0, 8'hFF, "R8 oe low write");

    // R8: address at opening, data at closing
    unlock(); bus_wr(18'h05555, 8'hA0);
    @(negedge clk); addr = 18'h04100; din = 8'h00; ce_n = 1'b0; we_n = 1'b0;
    @(negedge clk); addr = 18'h04140; din = 8'hC3; we_n = 1'b1;
    @(negedge clk); ce_n = 1'b1;
    idle(PROG_CYC + 4);
    rd_chk(18'h04100, 8'hC3, "R8 addr latch");
    rd_chk(18'h04140, 8'hFF, "R8 late addr unused");

    // R4/R5/R7: erase with lock set
    six(8'h10);
    bus_rd(18'h00000, v1, o1);
    bus_rd(18'h00000, v2, o1);
    chk(v1 & 8'hBF, 8'h00, "R7 erase status");
    chk({7'd0, v2[6]}, {7'd0, ~v1[6]}, "R7 erase toggle");
    idle(ERASE_CYC + 5);
    rd_chk(18'h00200, 8'h55, "R5 boot kept");
    rd_chk(18'h02000, 8'hFF, "R4 main erased");
    rd_chk(18'h04040, 8'hFF, "R4 main erased 2");

    // R1: reset mid-mode
    unlock(); bus_wr(18'h05555, 8'h90);
    @(negedge clk); rst_n = 1'b0;
    idle(2); rst_n = 1'b1; idle(1);
    rd_chk(18'h00001, 8'hFF, "R1 ident cleared");
    unlock(); bus_wr(18'h05555, 8'h90);
    rd_chk(18'h00002, 8'h00, "R1 lock cleared");
    bus_wr(18'h00000, 8'hF0);

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule